// File: doc/BRIEF.md
# Successive Approximation Conversion Sequencer

This block sequences an 8-bit successive-approximation analog-to-digital conversion. It presents a trial code to an external DAC, reads back one comparator bit each clock, and settles one result bit per clock, starting with the most significant bit. When the last bit is settled, the result is latched onto a parallel output and an active-low interrupt is asserted.

A conversion can be requested in two ways: by a falling edge on a dedicated start strobe, or by the point at which chip-select and read are both low at the same time. Both strobes are brought into the conversion clock domain through a synchroniser. The chip-select-and-read access also clears a pending interrupt. A separate interrupt-clear input forces the interrupt back high and has no effect on the conversion. A format input selects between straight binary and twos complement for both the trial code and the result.

The comparator, DAC, track-and-hold and reference are outside the block. The block sees them only as the comparator input.

Top module: `sar_conv_seq`

## Requirements
- R1: For a comparator that reads high when the analog input code is at or above the trial code, the latched straight-binary result equals the input code. Every W-bit code is converted exactly.
- R2: A conversion is requested by a falling edge of `start_n`, or by `cs_n` and `rd_n` becoming low together. Each strobe passes through SYNC flops and then an edge detector. `busy` rises after rising clock edge SYNC+1, counted from a strobe that is driven low mid-cycle.
- R3: On the accept edge, `trial_code` becomes the MSB alone (0x80 in straight binary). The MSB is decided on the next edge, and each lower bit on each edge after that. After decision edge d (d < W), the trial holds the d settled upper bits and has bit W-1-d set.
- R4: A start request from either strobe that arrives during a conversion is ignored. It does not alter that result, and no further conversion follows.
- R5: `irq_clr` drives `int_n` high on the next edge. It does not change the progress, timing or result of a conversion.
- R6: On the edge after the LSB decision (edge W+1 after accept), `result` is loaded, `int_n` goes low and `busy` falls.
- R7: A chip-select-and-read access returns `int_n` high on the same edge that accepts the access as a start. If a clear and a completion fall on the same edge, the completion wins. If `int_n` is never cleared, later conversions still produce correct results.
- R8: `result` holds its value until the next completion. Reset gives `result`=0, `int_n`=1, `busy`=0, and `trial_code`=0 when the format is straight binary.
- R9: With `fmt_twos`=1, bit W-1 of both `result` and `trial_code` is inverted relative to straight binary. The other bits are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous active-high reset |
| start_n | input | 1 | Dedicated start strobe, falling edge requests a conversion |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| irq_clr | input | 1 | Forces the interrupt high without affecting conversion |
| fmt_twos | input | 1 | 1 selects twos complement, 0 selects straight binary |
| cmp_hi | input | 1 | Comparator: input at or above the trial level |
| trial_code | output | 8 | Trial code to the external DAC |
| result | output | 8 | Latched conversion result |
| busy | output | 1 | High from accept until the result is latched |
| int_n | output | 1 | Active-low result-ready interrupt |

## Verification
The bench builds the block with W=8 and SYNC=2. At these sizes every input code can be converted in both output formats, and the cycle of each bit decision can be predicted exactly. A bench comparator model, driven from the trial code, lets the bench check every intermediate trial value as well as the final result. Some conversions are started through the chip-select-and-read path. Some receive a stray start and an interrupt clear in the middle of the conversion. This covers the ignore and clear rules at known cycles.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_CONV = 2'd1,
        SQ_DONE = 2'd2
    } seq_state_e;

    // Request events after synchronisation and edge detection
    typedef struct packed {
        logic from_access;
        logic from_start;
    } req_ev_t;

    localparam int unsigned NUM_REQ_SRC = 2;

endpackage

// File: rtl/sar_strobe_sync.sv
module sar_strobe_sync #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_n,
    output logic fall
);
    logic [SYNC-1:0] chain;
    logic            last;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;
            last  <= 1'b1;
        end else begin
            chain <= {chain[SYNC-1:0], strobe_n} [SYNC-1:0];
            last  <= chain[SYNC-1];
        end
    end

    assign fall = last & ~chain[SYNC-1];
endmodule

// File: rtl/sar_engine.sv
module sar_engine
    import sar_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_req,
    input  logic         cmp_hi,
    output logic [W-1:0] sar,
    output logic         busy,
    output logic         done
);
    localparam int PW = $clog2(W);
    localparam logic [PW-1:0] TOP_BIT = PW'(W - 1);
    localparam logic [W-1:0]  MSB_ONLY = {1'b1, {(W-1){1'b0}}};

    seq_state_e   st;
    logic [PW-1:0] ptr;
    logic [PW-1:0] ptr_dn;
    logic [W-1:0]  sar_nxt;

    assign ptr_dn = ptr - PW'(1);

    always_comb begin
        sar_nxt      = sar;
        sar_nxt[ptr] = cmp_hi;
        if (ptr != '0) sar_nxt[ptr_dn] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= SQ_IDLE;
            ptr <= '0;
            sar <= '0;
        end else begin
            case (st)
                SQ_IDLE: if (start_req) begin
                    st  <= SQ_CONV;
                    ptr <= TOP_BIT;
                    sar <= MSB_ONLY;
                end
                SQ_CONV: begin
                    sar <= sar_nxt;
                    if (ptr == '0) st  <= SQ_DONE;
                    else           ptr <= ptr_dn;
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    assign busy = (st != SQ_IDLE);
    assign done = (st == SQ_DONE);

    // R2: an accepted request loads the MSB trial
    p_accept_loads_msb_r2: assert property (@(posedge clk) disable iff (rst)
        (st == SQ_IDLE && start_req) |=> (st == SQ_CONV && ptr == TOP_BIT && sar == MSB_ONLY));
    // R3: one bit decided per clock, MSB first
    p_one_bit_per_clk_r3: assert property (@(posedge clk) disable iff (rst)
        (st == SQ_CONV && ptr != '0) |=> (st == SQ_CONV && ptr == $past(ptr) - PW'(1)));
    // R4: a request mid-conversion does not restart the sequence
    p_mid_request_ignored_r4: assert property (@(posedge clk) disable iff (rst)
        (st == SQ_CONV && ptr != TOP_BIT && start_req) |=> (ptr != TOP_BIT || st != SQ_CONV));
endmodule

// File: rtl/sar_result.sv
module sar_result #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         done,
    input  logic         twos,
    input  logic         clear_req,
    input  logic [W-1:0] sar,
    output logic [W-1:0] result,
    output logic         int_n
);
    logic [W-1:0] fmt_mask;
    assign fmt_mask = {twos, {(W-1){1'b0}}};

    always_ff @(posedge clk) begin
        if (rst) begin
            result <= '0;
            int_n  <= 1'b1;
        end else if (done) begin
            result <= sar ^ fmt_mask;
            int_n  <= 1'b0;
        end else if (clear_req) begin
            int_n  <= 1'b1;
        end
    end

    // R6: completion asserts the interrupt on the next edge
    p_int_on_done_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !int_n);
    // R5: a clear without completion releases the interrupt
    p_clear_releases_r5: assert property (@(posedge clk) disable iff (rst)
        (clear_req && !done) |=> int_n);
    // R8: result only moves on completion
    p_result_holds_r8: assert property (@(posedge clk) disable iff (rst)
        !done |=> $stable(result));
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
    import sar_pkg::*;
#(
    parameter int W    = 8,
    parameter int SYNC = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_n,
    input  logic         cs_n,
    input  logic         rd_n,
    input  logic         irq_clr,
    input  logic         fmt_twos,
    input  logic         cmp_hi,
    output logic [W-1:0] trial_code,
    output logic [W-1:0] result,
    output logic         busy,
    output logic         int_n
);
    logic [NUM_REQ_SRC-1:0] src_n;
    logic [NUM_REQ_SRC-1:0] src_fall;
    req_ev_t                ev;
    logic [W-1:0]           sar;
    logic                   done;

    assign src_n = {cs_n | rd_n, start_n};

    for (genvar i = 0; i < NUM_REQ_SRC; i++) begin : g_req
        sar_strobe_sync #(.SYNC(SYNC)) u_sync (
            .clk      (clk),
            .rst      (rst),
            .strobe_n (src_n[i]),
            .fall     (src_fall[i])
        );
    end

    assign ev = req_ev_t'(src_fall);

    sar_engine #(.W(W)) u_engine (
        .clk       (clk),
        .rst       (rst),
        .start_req (ev.from_start | ev.from_access),
        .cmp_hi    (cmp_hi),
        .sar       (sar),
        .busy      (busy),
        .done      (done)
    );

    sar_result #(.W(W)) u_result (
        .clk       (clk),
        .rst       (rst),
        .done      (done),
        .twos      (fmt_twos),
        .clear_req (irq_clr | ev.from_access),
        .sar       (sar),
        .result    (result),
        .int_n     (int_n)
    );

    assign trial_code = sar ^ {fmt_twos, {(W-1){1'b0}}};

    // R6: busy ends exactly when the interrupt is raised
    p_busy_ends_with_int_r6: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy)) |-> !int_n);
endmodule

// File: tb/test_sar_conv_seq.sv
module test_sar_conv_seq;
    localparam int W    = 8;
    localparam int SYNC = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_n = 1'b1, cs_n = 1'b1, rd_n = 1'b1, irq_clr = 1'b0, fmt_twos = 1'b0;
    logic cmp_hi;
    logic [W-1:0] trial_code, result, vin;
    logic busy, int_n;

    int vectors = 0;
    int misses  = 0;

    always #2 clk = ~clk;

    sar_conv_seq #(.W(W), .SYNC(SYNC)) i_sar_conv_seq (
        .clk(clk), .rst(rst), .start_n(start_n), .cs_n(cs_n), .rd_n(rd_n),
        .irq_clr(irq_clr), .fmt_twos(fmt_twos), .cmp_hi(cmp_hi),
        .trial_code(trial_code), .result(result), .busy(busy), .int_n(int_n)
    );

    function automatic logic [W-1:0] fmtc(input logic [W-1:0] c, input logic tw);
        return c ^ {tw, {(W-1){1'b0}}};
    endfunction

    // comparator model: high when the input is at or above the trial level
    assign cmp_hi = (vin >= fmtc(trial_code, fmt_twos));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic do_conv(input int v, input bit tw, input bit via_acc, input bit inject);
        logic [W-1:0] exp_trial;
        vin = W'(v);
        fmt_twos = tw;
        @(negedge clk);
        if (via_acc) begin cs_n = 1'b0; rd_n = 1'b0; end
        else start_n = 1'b0;
        repeat (SYNC) @(posedge clk);
        @(negedge clk);
        chk("R2 busy before accept", busy, 0);
        @(posedge clk); @(negedge clk);
        chk("R2 busy at accept", busy, 1);
        chk("R3 msb trial", trial_code, fmtc(W'(1) << (W-1), tw));
        if (via_acc) chk("R7 access clears int", int_n, 1);
        start_n = 1'b1; cs_n = 1'b1; rd_n = 1'b1;
        for (int d = 1; d <= W; d++) begin
            @(posedge clk); @(negedge clk);
            chk("R6 busy during conversion", busy, 1);
            if (d < W) begin
                exp_trial = ((W'(v) >> (W-d)) << (W-d)) | (W'(1) << (W-1-d));
                chk("R3 trial after decision", trial_code, fmtc(exp_trial, tw));
            end
            if (inject && d == 3) begin start_n = 1'b0; irq_clr = 1'b1; end
            if (inject && d == 4) begin
                irq_clr = 1'b0;
                chk("R5 irq_clr releases int", int_n, 1);
            end
            if (inject && d == 5) start_n = 1'b1;
        end
        @(posedge clk); @(negedge clk);
        chk("R6 busy falls", busy, 0);
        chk("R6 int asserted", int_n, 0);
        chk(tw ? "R9 twos result" : "R1 binary result", result, fmtc(W'(v), tw));
        if (inject) begin
            vin = ~W'(v);
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                chk("R4 no extra conversion", busy, 0);
            end
            chk("R8 result held", result, fmtc(W'(v), tw));
        end
    endtask

    initial begin
        vin = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R8 reset result", result, 0);
        chk("R8 reset int_n", int_n, 1);
        chk("R8 reset busy", busy, 0);
        chk("R8 reset trial", trial_code, 0);
        // R7: no reads between conversions, results must stay correct
        for (int m = 0; m < 2; m++)
            for (int v = 0; v < (1 << W); v++)
                do_conv(v, bit'(m), (v % 16) == 5, (v % 32) == 9);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        misses++;
        $display("FAIL watchdog act=hung exp=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule